// File: doc/BRIEF.md
# Dual-Slot DMA Descriptor Sequencer

This block holds two descriptors for a DMA engine that copies words from a remote source bus to a local destination bus. Each descriptor has two registers: a source word address and a control word. The control word carries a start flag, a byte-order flag and a 16-bit word count. Software on the local side programs the descriptors through a write/read register port. Agents on the remote side can read the same registers but cannot write them.

A sequencer picks up enabled descriptors one at a time. For each word it issues a read request on a valid/ready source interface and waits for the response. It byte-reverses the word if the descriptor asks for that, then offers it on a valid/ready destination interface. When the last word is written, the hardware clears that descriptor's start flag and pulses a completion strobe tagged with the slot number. With two slots, software can queue a second job while the first one is running.

Register select encoding, used on both ports: bit 1 selects the slot, and bit 0 selects the register within the slot (0 = address register, 1 = control register).

Top module: `dma_desc_queue`

## Requirements
- R1: After reset, all four registers read zero on both ports, and `src_req_valid`, `dst_valid` and `done_pulse` are low.
- R2: The address register stores written bits 31:2. Bits 1:0 always read as zero.
- R3: The control register holds the start flag at bit 31, the swap flag at bit 28 and the word count at bits 15:0. All other bits read as zero, whatever was written to them.
- R4: The remote read port returns the same value as the local read port for every register select. The remote side has no write path.
- R5: An enabled descriptor with a nonzero count N issues exactly N source reads, at the programmed byte address plus 4 times the word index. Each returned word goes to the destination in the same order. The first request is valid in the second cycle after the enabling write.
- R6: With the swap flag at 1, each destination word is the source word with its four bytes reversed. With the flag at 0, the word passes through unchanged.
- R7: In the cycle after the final destination handshake, `done_pulse` is high for one cycle with `done_idx` equal to the slot number, and the start flag of that slot reads zero.
- R8: A descriptor enabled with a zero count makes no bus access. Its start flag clears one cycle after the write, and a done pulse is still raised for it.
- R9: When both slots are enabled, they are served alternately. Slot 0 is served first after reset, and after any completion the other slot takes priority. A slot enabled while the other slot is running waits for that transfer to finish.
- R10: While a slot is running, local writes to either of its registers are ignored, and its programmed fields stay unchanged.
- R11: At most one word is in flight at any time. A request or write offer that is not yet accepted keeps its valid high and its address or data stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_wr | input | 1 | Local register write strobe |
| loc_sel | input | 2 | Local register select: bit 1 = slot, bit 0 = 0 address / 1 control |
| loc_wdata | input | 32 | Local write data |
| loc_rdata | output | 32 | Local read data (combinational) |
| rem_sel | input | 2 | Remote register select, same encoding as `loc_sel` |
| rem_rdata | output | 32 | Remote read data (combinational) |
| src_req_valid | output | 1 | Source read request valid |
| src_req_ready | input | 1 | Source accepts the request |
| src_addr | output | 32 | Source byte address of the requested word |
| src_rsp_valid | input | 1 | Source read data valid |
| src_rsp_ready | output | 1 | Sequencer accepts the read data |
| src_rsp_data | input | 32 | Source read data |
| dst_valid | output | 1 | Destination write valid |
| dst_ready | input | 1 | Destination accepts the word |
| dst_data | output | 32 | Destination word |
| done_pulse | output | 1 | One-cycle completion strobe |
| done_idx | output | 1 | Slot that completed |

## Verification
Register reads are combinational, so a write made at one edge is checked at the next falling edge. A zero-count enable is checked twice: still set at the first falling edge after the write, and clear at the second. The first source request is sampled one full cycle after the enabling write. Completion is observed at the falling edge after the final destination handshake, when the done strobe is high. The source and destination models in the bench log each handshake one falling edge after the edge where it takes place, so every comparison reads settled values and never depends on process order at a clock edge.

// File: rtl/dma_desc_queue.sv
module dma_desc_queue (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        loc_wr,
  input  logic [1:0]  loc_sel,
  input  logic [31:0] loc_wdata,
  output logic [31:0] loc_rdata,
  input  logic [1:0]  rem_sel,
  output logic [31:0] rem_rdata,
  output logic        src_req_valid,
  input  logic        src_req_ready,
  output logic [31:0] src_addr,
  input  logic        src_rsp_valid,
  output logic        src_rsp_ready,
  input  logic [31:0] src_rsp_data,
  output logic        dst_valid,
  input  logic        dst_ready,
  output logic [31:0] dst_data,
  output logic        done_pulse,
  output logic        done_idx
);
  localparam int GO_BIT   = 31;
  localparam int SWAP_BIT = 28;
  localparam int CNT_W    = 16;
  localparam logic [31:0] CTRL_MASK = (32'h1 << GO_BIT) | (32'h1 << SWAP_BIT) | ((32'h1 << CNT_W) - 32'h1);
  localparam logic [31:0] ADDR_MASK = 32'hFFFF_FFFC;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP, S_WR} state_t;

  state_t            state_q;
  logic [31:0]       base_q [2];
  logic [31:0]       ctrl_q [2];
  logic              act_q, ptr_q;
  logic [29:0]       cur_q;
  logic [CNT_W-1:0]  left_q;
  logic [31:0]       word_q;

  function automatic logic [31:0] view(input logic [1:0] s);
    view = s[0] ? ctrl_q[s[1]] : base_q[s[1]];
  endfunction

  function automatic logic [31:0] bswap(input logic [31:0] d);
    bswap = {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  assign loc_rdata = view(loc_sel);
  assign rem_rdata = view(rem_sel);

  logic busy, wr_ok, pick, start;
  assign busy  = state_q != S_IDLE;
  assign wr_ok = loc_wr && !(busy && act_q == loc_sel[1]);
  assign pick  = ctrl_q[ptr_q][GO_BIT] ? ptr_q : ~ptr_q;
  assign start = !busy && !loc_wr && (ctrl_q[0][GO_BIT] || ctrl_q[1][GO_BIT]);

  assign src_req_valid = state_q == S_REQ;
  assign src_addr      = {cur_q, 2'b00};
  assign src_rsp_ready = state_q == S_RSP;
  assign dst_valid     = state_q == S_WR;
  assign dst_data      = word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      base_q[0]  <= '0;
      base_q[1]  <= '0;
      ctrl_q[0]  <= '0;
      ctrl_q[1]  <= '0;
      act_q      <= 1'b0;
      ptr_q      <= 1'b0;
      cur_q      <= '0;
      left_q     <= '0;
      word_q     <= '0;
      done_pulse <= 1'b0;
      done_idx   <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      if (wr_ok) begin
        if (loc_sel[0]) ctrl_q[loc_sel[1]] <= loc_wdata & CTRL_MASK;
        else            base_q[loc_sel[1]] <= loc_wdata & ADDR_MASK;
      end
      case (state_q)
        S_IDLE: if (start) begin
          act_q <= pick;
          if (ctrl_q[pick][CNT_W-1:0] == '0) begin
            ctrl_q[pick][GO_BIT] <= 1'b0;
            done_pulse <= 1'b1;
            done_idx   <= pick;
            ptr_q      <= ~pick;
          end else begin
            cur_q   <= base_q[pick][31:2];
            left_q  <= ctrl_q[pick][CNT_W-1:0];
            state_q <= S_REQ;
          end
        end
        S_REQ: if (src_req_ready) state_q <= S_RSP;
        S_RSP: if (src_rsp_valid) begin
          word_q  <= ctrl_q[act_q][SWAP_BIT] ? bswap(src_rsp_data) : src_rsp_data;
          state_q <= S_WR;
        end
        S_WR: if (dst_ready) begin
          cur_q  <= cur_q + 30'd1;
          left_q <= left_q - 1'b1;
          if (left_q == 1) begin
            ctrl_q[act_q][GO_BIT] <= 1'b0;
            done_pulse <= 1'b1;
            done_idx   <= act_q;
            ptr_q      <= ~act_q;
            state_q    <= S_IDLE;
          end else begin
            state_q <= S_REQ;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    src_req_valid && !src_req_ready |=> src_req_valid && $stable(src_addr));

  assert_dst_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid && !dst_ready |=> dst_valid && $stable(dst_data));

  assert_done_clears_go_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> !ctrl_q[done_idx][GO_BIT]);

  assert_active_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(base_q[act_q]) && $stable(ctrl_q[act_q][CNT_W-1:0]) && $stable(ctrl_q[act_q][SWAP_BIT]));

  assert_zero_count_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start && ctrl_q[pick][CNT_W-1:0] == '0 |=> !src_req_valid && done_pulse);

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |-> !src_req_valid && !src_rsp_ready);
endmodule

// File: tb/test_dma_desc_queue.sv
`timescale 1ns/1ps
module test_dma_desc_queue;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, loc_wr, src_req_ready, src_rsp_valid, dst_ready;
  logic [1:0] loc_sel, rem_sel;
  logic [31:0] loc_wdata, src_rsp_data;
  logic [31:0] loc_rdata, rem_rdata, src_addr, dst_data;
  logic src_req_valid, src_rsp_ready, dst_valid, done_pulse, done_idx;

  dma_desc_queue i_dma_desc_queue (
    .clk(clk), .rst_n(rst_n), .loc_wr(loc_wr), .loc_sel(loc_sel), .loc_wdata(loc_wdata),
    .loc_rdata(loc_rdata), .rem_sel(rem_sel), .rem_rdata(rem_rdata),
    .src_req_valid(src_req_valid), .src_req_ready(src_req_ready), .src_addr(src_addr),
    .src_rsp_valid(src_rsp_valid), .src_rsp_ready(src_rsp_ready), .src_rsp_data(src_rsp_data),
    .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_data(dst_data),
    .done_pulse(done_pulse), .done_idx(done_idx));

  int nchk = 0, nfail = 0;
  bit finished = 0;
  bit stall = 0;
  int cyc = 0;
  int nreq = 0, nwr = 0, ndone = 0;
  logic [31:0] req_log [64];
  logic [31:0] wr_log [64];
  logic        done_log [64];
  logic rf = 0, pf = 0, df = 0;
  logic [31:0] ra = '0, wd = '0;

  function automatic logic [31:0] srcword(input logic [31:0] a);
    srcword = a ^ 32'hA1B2_C3D4;
  endfunction
  function automatic logic [31:0] rev(input logic [31:0] d);
    rev = {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  // source and destination models, driven on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (pf) src_rsp_valid = 1'b0;
    if (rf) begin
      src_rsp_valid = 1'b1;
      src_rsp_data  = srcword(ra);
      req_log[nreq[5:0]] = ra;
      nreq++;
    end
    if (df) begin wr_log[nwr[5:0]] = wd; nwr++; end
    if (done_pulse) begin done_log[ndone[5:0]] = done_idx; ndone++; end
    src_req_ready = stall ? cyc[1] : 1'b1;
    dst_ready     = stall ? cyc[0] : 1'b1;
    rf = src_req_valid && src_req_ready; ra = src_addr;
    pf = src_rsp_valid && src_rsp_ready;
    df = dst_valid && dst_ready; wd = dst_data;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    loc_wr = 1'b1; loc_sel = s; loc_wdata = d;
    @(negedge clk);
    loc_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] l, output logic [31:0] r);
    loc_sel = s; rem_sel = s;
    #1;
    l = loc_rdata; r = rem_rdata;
  endtask

  task automatic wait_done(input int target);
    for (int k = 0; k < 2000 && ndone < target; k++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  // {select, write data, expected read}
  localparam logic [65:0] TBL [6] = '{
    {2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFC},
    {2'd1, 32'h7FFF_ABCD, 32'h1000_ABCD},
    {2'd2, 32'h1234_5677, 32'h1234_5674},
    {2'd3, 32'h0FFF_0001, 32'h0000_0001},
    {2'd3, 32'h0000_0000, 32'h0000_0000},
    {2'd1, 32'h0000_0000, 32'h0000_0000}
  };

  initial begin
    logic [31:0] l, r;
    int b0, w0, d0;
    loc_wr = 0; loc_sel = 0; rem_sel = 0; loc_wdata = 0;
    src_req_ready = 1; src_rsp_valid = 0; src_rsp_data = 0; dst_ready = 1;
    do_reset();

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd(s[1:0], l, r);
      check("R1 local reset value", l, 32'h0);
      check("R1 remote reset value", r, 32'h0);
    end
    check("R1 outputs idle", {29'd0, src_req_valid, dst_valid, done_pulse}, 32'h0);

    // R2 R3 R4 register table
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      wr(TBL[i][65:64], TBL[i][63:32]);
      rd(TBL[i][65:64], l, r);
      if (TBL[i][64]) check("R3 control readback", l, TBL[i][31:0]);
      else            check("R2 address readback", l, TBL[i][31:0]);
      check("R4 remote mirrors local", r, TBL[i][31:0]);
    end

    // R5 R7 R10 plain transfer on slot 0
    @(negedge clk);
    b0 = nreq; w0 = nwr; d0 = ndone;
    wr(2'd0, 32'h0000_1000);
    wr(2'd1, 32'h8000_0003);
    @(negedge clk); #1;
    check("R5 first request timing", {31'd0, src_req_valid}, 32'd1);
    check("R5 first request address", src_addr, 32'h0000_1000);
    wait_done(d0 + 1);
    check("R5 read count", nreq - b0, 3);
    check("R5 write count", nwr - w0, 3);
    for (int k = 0; k < 3; k++) begin
      check("R5 request address", req_log[b0 + k], 32'h1000 + 4 * k);
      check("R5 passthrough data", wr_log[w0 + k], srcword(32'h1000 + 4 * k));
    end
    check("R7 done slot", {31'd0, done_log[d0]}, 32'd0);
    rd(2'd1, l, r);
    check("R7 start flag cleared", l, 32'h0000_0003);
    rd(2'd0, l, r);
    check("R10 address unchanged", l, 32'h0000_1000);
    @(negedge clk); #1;
    check("R7 pulse one cycle", {31'd0, done_pulse}, 32'd0);

    // R6 R11 swapped transfer on slot 1 with stalls
    stall = 1;
    b0 = nreq; w0 = nwr; d0 = ndone;
    wr(2'd2, 32'h0000_4000);
    wr(2'd3, 32'h9000_0002);
    wait_done(d0 + 1);
    stall = 0;
    check("R11 reads under stall", nreq - b0, 2);
    for (int k = 0; k < 2; k++) begin
      check("R11 address under stall", req_log[b0 + k], 32'h4000 + 4 * k);
      check("R6 swapped data", wr_log[w0 + k], rev(srcword(32'h4000 + 4 * k)));
    end
    check("R7 done slot 1", {31'd0, done_log[d0]}, 32'd1);

    // R8 zero count
    @(negedge clk);
    b0 = nreq; d0 = ndone;
    wr(2'd1, 32'h8000_0000);
    rd(2'd1, l, r);
    check("R8 flag set right after write", l, 32'h8000_0000);
    @(negedge clk);
    rd(2'd1, l, r);
    check("R8 flag cleared next cycle", l, 32'h0);
    repeat (3) @(negedge clk);
    #1;
    check("R8 no bus access", nreq - b0, 0);
    check("R8 done raised", ndone - d0, 1);
    check("R8 done slot", {31'd0, done_log[d0]}, 32'd0);

    // R9 R10 queueing and alternation
    do_reset();
    @(negedge clk);
    d0 = ndone; b0 = nreq;
    wr(2'd0, 32'h0000_5000);
    wr(2'd2, 32'h0000_6000);
    wr(2'd3, 32'h8000_0001);
    wr(2'd1, 32'h8000_0002);
    @(negedge clk);
    wr(2'd1, 32'h0000_0000);
    rd(2'd1, l, r);
    check("R10 write to active slot ignored", l, 32'h8000_0002);
    wait_done(d0 + 2);
    check("R9 slot 0 first after reset", {31'd0, done_log[d0]}, 32'd0);
    check("R9 slot 1 second", {31'd0, done_log[d0 + 1]}, 32'd1);
    check("R9 first request slot 0 address", req_log[b0], 32'h5000);
    @(negedge clk);
    d0 = ndone;
    wr(2'd1, 32'h8000_0001);
    wait_done(d0 + 1);
    @(negedge clk);
    d0 = ndone; b0 = nreq;
    wr(2'd1, 32'h8000_0001);
    wr(2'd3, 32'h8000_0001);
    wait_done(d0 + 2);
    check("R9 alternation picks slot 1", {31'd0, done_log[d0]}, 32'd1);
    check("R9 then slot 0", {31'd0, done_log[d0 + 1]}, 32'd0);
    check("R9 slot 1 address first", req_log[b0], 32'h6000);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule